// File: doc/BRIEF.md
# Precomputed Harmonic-Mitigation PWM Sequencer

This block plays back a three-level, three-phase switching pattern whose edge positions were worked out offline to keep low-order harmonics under grid limits at a very low device switching rate. The pattern is held as lists of wait counts: each entry says how many clock cycles the current level is kept before the next edge. One list (a table row) exists per modulation index. An outer voltage regulator chooses the row through `row_i`. The sequencer reads the chosen row cyclically for as long as it is enabled.

Only one quarter of the fundamental is stored per row. A row holds the gaps between 15 edges plus a final gap that runs up to the quarter boundary, and these gaps add up to `QUARTER_CYC` cycles. Quarters 1 and 3 read the row from first entry to last. Quarters 2 and 4 read it from last entry to first, so each half wave is a mirror image about its middle. The second half repeats the first with the active level negated. Phase A starts at the enabling clock edge. Phases B and C run the same playback one third and two thirds of a period later. Each phase takes a new row only at the start of its own period. Phase A marks each of its period starts with a one-cycle strobe that the regulator can use.

The built-in table is a computed sample pattern, so the block can be checked on its own. A deployed table is generated offline, and its `QUARTER_CYC` is the quarter of a 50 Hz period in clock cycles. With 15 edges per quarter, that gives a device switching rate of 750 Hz.

Top module: `hm_pwm_sequencer`

## Requirements
- R1: While reset is held, and while `en_i` is low, `lvl_o` is all zero and `period_start_o` is 0. Each phase uses a 2-bit level code: 2'b00 is 0, 2'b01 is +1 and 2'b11 is -1. Phase A is `lvl_o[1:0]`, phase B is `lvl_o[3:2]` and phase C is `lvl_o[5:4]`.
- R2: Row r holds wait counts g(r,k) = 3 + ((r+k) mod 4) for k = 0..14. Its final entry g(r,15) is `QUARTER_CYC` minus the sum of the other 15, so every quarter lasts exactly `QUARTER_CYC` cycles.
- R3: In quarter 1 a phase starts at level 0. It changes between 0 and +1 after each of g(r,0)..g(r,14) cycles, and it holds for g(r,15) cycles up to the quarter boundary.
- R4: Quarter 2 is the time mirror of quarter 1, read from g(r,15) down to g(r,0). It starts at +1 and ends at 0, and the level at quarter offset v equals the quarter-1 level at offset `QUARTER_CYC`-1-v.
- R5: Quarters 3 and 4 repeat quarters 1 and 2 with -1 in place of +1.
- R6: Each phase samples `row_i` only in the first cycle of each of its periods. A change of `row_i` at any other time has no effect on that phase until its next period.
- R7: `period_start_o` is high for exactly one cycle, which is the first cycle of every phase-A period. Periods last 4*`QUARTER_CYC` cycles.
- R8: Phase B starts its first period (4*`QUARTER_CYC`)/3 cycles after phase A, and phase C starts 2*(4*`QUARTER_CYC`)/3 cycles after phase A. Each phase stays at 0 until it starts.
- R9: When `en_i` goes low, all levels are 0 from the next cycle on. A later enable restarts all three phases from the beginning.
- R10: Phase A's first period begins in the cycle after the first rising clock edge that sees `en_i` high. In that cycle the strobe is high and phase A is at level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable; low forces all phases idle |
| row_i | input | $clog2(NROWS) | Modulation-index row select |
| lvl_o | output | 6 | Three 2-bit phase levels (A low, C high) |
| period_start_o | output | 1 | One-cycle strobe at each phase-A period start |

## Verification
The bench builds the block with its default parameters: 8 rows, 15 edges per quarter and a 96-cycle quarter. That makes a period 384 cycles long, with phases B and C starting at offsets 128 and 256. With these values, every row can be played for whole periods in a few thousand cycles, and every cycle of all three phases can be compared against the mirrored-gap arithmetic. The row input is changed in the middle of periods, and each phase picks up rows at its own boundaries, so row latching is tested for all three phase offsets. Dropping and raising the enable mid-run checks the forced-idle behaviour and the restart.

// File: rtl/hm_pkg.sv
package hm_pkg;

  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;

  // Sample pattern: small gaps before each edge, remainder closes the quarter.
  function automatic int unsigned gap_of(int unsigned row, int unsigned step,
                                         int unsigned nedge, int unsigned qc);
    int unsigned acc;
    acc = 0;
    if (step < nedge) return 3 + ((row + step) % 4);
    for (int unsigned k = 0; k < nedge; k++) acc += 3 + ((row + k) % 4);
    return qc - acc;
  endfunction

endpackage

// File: rtl/hm_gap_table.sv
module hm_gap_table #(
  parameter int unsigned NROWS = 8,
  parameter int unsigned NEDGE = 15,
  parameter int unsigned QC    = 96,
  parameter int unsigned NPORT = 3,
  parameter int unsigned RW    = 3,
  parameter int unsigned SW    = 4,
  parameter int unsigned CW    = 7
) (
  input  logic [NPORT*RW-1:0] rd_row_i,
  input  logic [NPORT*SW-1:0] rd_step_i,
  output logic [NPORT*CW-1:0] gap_o
);
  localparam int unsigned NSTEP = NEDGE + 1;
  localparam int unsigned DEPTH = NROWS * NSTEP;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic [CW-1:0] rom [DEPTH];

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    for (genvar k = 0; k < NSTEP; k++) begin : g_ent
      assign rom[r*NSTEP + k] = CW'(hm_pkg::gap_of(r, k, NEDGE, QC));
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [RW-1:0] row_c;
    logic [AW-1:0] addr;
    always_comb begin
      row_c = rd_row_i[p*RW +: RW];
      if (int'(row_c) >= NROWS) row_c = RW'(NROWS - 1);
      addr = AW'(row_c) * AW'(NSTEP) + AW'(rd_step_i[p*SW +: SW]);
    end
    assign gap_o[p*CW +: CW] = rom[addr];
  end

endmodule

// File: rtl/hm_phase_seq.sv
module hm_phase_seq #(
  parameter int unsigned NEDGE = 15,
  parameter int unsigned RW    = 3,
  parameter int unsigned SW    = 4,
  parameter int unsigned CW    = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          go_i,
  input  logic [RW-1:0] row_i,
  input  logic [CW-1:0] gap_i,
  output logic [RW-1:0] rd_row_o,
  output logic [SW-1:0] rd_step_o,
  output logic [1:0]    lvl_o,
  output logic          start_o
);
  localparam logic [SW-1:0] LAST = SW'(NEDGE);

  logic          run_q, mag_q, start_q;
  logic [1:0]    qtr_q, nx_qtr;
  logic [SW-1:0] step_q, nx_step;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] row_q;
  logic          nx_tog, wrap;

  // Next table entry: forward in odd-numbered quarters, backward in even ones.
  always_comb begin
    nx_qtr  = qtr_q;
    nx_step = step_q;
    nx_tog  = 1'b0;
    wrap    = 1'b0;
    if (!qtr_q[0]) begin
      if (step_q != LAST) begin
        nx_step = step_q + SW'(1);
        nx_tog  = 1'b1;
      end else begin
        nx_qtr = qtr_q + 2'd1;
      end
    end else begin
      if (step_q != '0) begin
        nx_step = step_q - SW'(1);
        nx_tog  = 1'b1;
      end else begin
        nx_qtr = qtr_q + 2'd1;
        wrap   = (qtr_q == 2'd3);
      end
    end
    rd_row_o  = (!run_q || wrap) ? row_i : row_q;
    rd_step_o = run_q ? nx_step : '0;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      run_q <= 1'b0; mag_q <= 1'b0; start_q <= 1'b0;
      qtr_q <= '0; step_q <= '0; cnt_q <= '0; row_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (!en_i) begin
        run_q <= 1'b0; mag_q <= 1'b0;
        qtr_q <= '0; step_q <= '0; cnt_q <= '0;
      end else if (!run_q) begin
        if (go_i) begin
          run_q   <= 1'b1;
          qtr_q   <= '0;
          step_q  <= '0;
          cnt_q   <= gap_i;
          row_q   <= row_i;
          mag_q   <= 1'b0;
          start_q <= 1'b1;
        end
      end else if (cnt_q == CW'(1)) begin
        qtr_q  <= nx_qtr;
        step_q <= nx_step;
        cnt_q  <= gap_i;
        if (nx_tog) mag_q <= ~mag_q;
        if (wrap) begin
          row_q   <= row_i;
          start_q <= 1'b1;
        end
      end else begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  assign lvl_o   = mag_q ? (qtr_q[1] ? hm_pkg::LVL_NEG : hm_pkg::LVL_POS) : hm_pkg::LVL_ZERO;
  assign start_o = start_q;

  // R3: a running phase always has a live wait count
  p_cnt_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q != '0);

  // R3: level is held while the wait count has not expired
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && $past(cnt_q) != CW'(1)) |-> $stable(lvl_o));

  // R4: the active level at each quarter entry follows the mirror rule
  p_qtr_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && $past(run_q) && qtr_q != $past(qtr_q)) |-> mag_q == qtr_q[0]);

  // R7: period strobe lasts one cycle
  p_strobe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);

endmodule

// File: rtl/hm_pwm_sequencer.sv
module hm_pwm_sequencer #(
  parameter int unsigned NROWS       = 8,
  parameter int unsigned NEDGE       = 15,
  parameter int unsigned QUARTER_CYC = 96,
  localparam int unsigned RW         = (NROWS > 1) ? $clog2(NROWS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [RW-1:0] row_i,
  output logic [5:0]    lvl_o,
  output logic          period_start_o
);
  localparam int unsigned NPH    = 3;
  localparam int unsigned SW     = $clog2(NEDGE + 1);
  localparam int unsigned CW     = $clog2(QUARTER_CYC + 1);
  localparam int unsigned PERIOD = 4 * QUARTER_CYC;
  localparam int unsigned OFF_B  = PERIOD / 3;
  localparam int unsigned OFF_C  = (2 * PERIOD) / 3;
  localparam int unsigned DW     = $clog2(OFF_C + 1);

  logic [DW-1:0]     dly_q;
  logic [NPH-1:0]    go, starts;
  logic [NPH*RW-1:0] rd_row;
  logic [NPH*SW-1:0] rd_step;
  logic [NPH*CW-1:0] gap;

  // Time since enable, saturating once the last phase has been launched.
  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i)      dly_q <= '0;
    else if (dly_q != DW'(OFF_C)) dly_q <= dly_q + DW'(1);
  end

  hm_gap_table #(
    .NROWS(NROWS), .NEDGE(NEDGE), .QC(QUARTER_CYC), .NPORT(NPH),
    .RW(RW), .SW(SW), .CW(CW)
  ) tbl_i (
    .rd_row_i (rd_row),
    .rd_step_i(rd_step),
    .gap_o    (gap)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    localparam int unsigned OFF = (p * PERIOD) / 3;
    assign go[p] = en_i && (dly_q == DW'(OFF));

    hm_phase_seq #(.NEDGE(NEDGE), .RW(RW), .SW(SW), .CW(CW)) seq_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_i),
      .go_i     (go[p]),
      .row_i    (row_i),
      .gap_i    (gap[p*CW +: CW]),
      .rd_row_o (rd_row[p*RW +: RW]),
      .rd_step_o(rd_step[p*SW +: SW]),
      .lvl_o    (lvl_o[p*2 +: 2]),
      .start_o  (starts[p])
    );
  end

  assign period_start_o = starts[0];

  // R9: disabling forces every phase to zero on the next cycle
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (lvl_o == '0 && !period_start_o));

  // R8: phase period starts never coincide
  p_start_spread_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(starts));

  // R10: phase A opens each period at level 0
  p_open_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_o |-> lvl_o[1:0] == 2'b00);

  // R8: phase B idle until its offset has elapsed
  p_b_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_q < DW'(OFF_B)) |-> lvl_o[3:2] == 2'b00);

endmodule

// File: tb/hm_pwm_sequencer_tb_top.sv
`timescale 1ns/1ps
module hm_pwm_sequencer_tb_top;
  localparam int NROWS  = 8;
  localparam int NEDGE  = 15;
  localparam int QC     = 96;
  localparam int PERIOD = 4 * QC;
  localparam int RW     = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [RW-1:0] row = '0;
  logic [5:0]    lvl;
  logic          pstart;

  int checks = 0;
  int errs = 0;
  int t = -1;
  int rowp [3];
  int off [3];
  bit had_run = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hm_pwm_sequencer #(.NROWS(NROWS), .NEDGE(NEDGE), .QUARTER_CYC(QC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .row_i(row),
    .lvl_o(lvl), .period_start_o(pstart)
  );

  function automatic int gap(int r, int k);
    int s = 0;
    if (k < NEDGE) return 3 + ((r + k) % 4);
    for (int j = 0; j < NEDGE; j++) s += 3 + ((r + j) % 4);
    return QC - s;
  endfunction

  // Level from cumulative edge positions, mirrored in even-numbered quarters.
  function automatic logic [1:0] lvl_at(int r, int u);
    int q = u / QC;
    int v = u % QC;
    int w = (q % 2 == 1) ? (QC - 1 - v) : v;
    int c = 0;
    int n = 0;
    for (int k = 0; k < NEDGE; k++) begin
      c += gap(r, k);
      if (c <= w) n++;
    end
    if (n % 2 == 0) return 2'b00;
    return (q >= 2) ? 2'b11 : 2'b01;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
    end
  endtask

  // Called just after a falling edge: model the cycle that the last rising edge opened.
  task automatic sample();
    if (en) t = (t < 0) ? 0 : t + 1;
    else t = -1;
    if (t >= 0) had_run = 1'b1;
    for (int p = 0; p < 3; p++) begin
      int tp = t - off[p];
      int e;
      string tag;
      if (t < 0) begin
        e = 0; tag = had_run ? "R9" : "R1";
      end else if (tp < 0) begin
        e = 0; tag = "R8";
      end else begin
        int u = tp % PERIOD;
        if (u == 0) rowp[p] = int'(row);
        e = int'(lvl_at(rowp[p], u));
        if (p == 0 && t == 0) tag = "R10";
        else if (int'(row) != rowp[p]) tag = "R6";
        else if (u / QC == 0 && (u % QC) >= QC - gap(rowp[p], NEDGE)) tag = "R2";
        else if (u / QC == 0) tag = "R3";
        else if (u / QC == 1) tag = "R4";
        else tag = "R5";
      end
      check(tag, int'(lvl[p*2 +: 2]), e);
    end
    check((t == 0) ? "R10" : "R7", int'(pstart), (t >= 0 && t % PERIOD == 0) ? 1 : 0);
  endtask

  // Row for the cycle after the next edge: steps per period, with a detour mid-period.
  task automatic drive_row();
    int tn = t + 1;
    int base = (tn / PERIOD) % NROWS;
    int u = tn % PERIOD;
    if (u > PERIOD / 3 && u < (2 * PERIOD) / 3 + 5) row = RW'((base + 3) % NROWS);
    else row = RW'(base);
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample();
      drive_row();
    end
  endtask

  initial begin
    off[0] = 0; off[1] = PERIOD / 3; off[2] = (2 * PERIOD) / 3;
    for (int p = 0; p < 3; p++) rowp[p] = 0;
    // R1: reset then idle
    repeat (5) begin @(negedge clk); sample(); end
    rst_n = 1'b1;
    repeat (4) begin @(negedge clk); sample(); end
    // R10/R3..R8: enable and sweep rows over whole periods
    en = 1'b1;
    row = '0;
    cycles(PERIOD * 9 + 40);
    // R9: disable mid-run, then restart
    en = 1'b0;
    cycles(6);
    en = 1'b1;
    row = '0;
    cycles(PERIOD + PERIOD / 2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end

endmodule